// File: doc/BRIEF.md
# Prioritized Core Event Controller

This block arbitrates sixteen event levels for a processor core. Requests arrive as single-cycle pulses and are held in a latch register. They are qualified by a mask register, and the controller tracks nesting in a pending register. Each cycle it looks at the most urgent latched and enabled level and decides whether the core must enter that handler now. When it does, it issues a one-cycle take strobe. The strobe carries the level, the return-address register the core must fill, the value to write there, and a flag that redirects the vector fetch to the reset vector.

The core also uses the block to leave handlers. A return request names one of four return kinds, and the block checks that the kind fits the level currently running. A legal return retires the level. An illegal return raises an exception request instead. Small side operations cover the remaining handler-entry housekeeping: saving or restoring the interrupt return register, and disabling interrupts. A 32-bit register port gives software access to the five control registers. Level 0 is the most urgent; level 4 is never an event and serves as the global-disable flag inside the pending register.

Top module: `evt_core`

## Requirements
- R1: Word address 0 is the override register (all 32 bits stored), 1 the mask, 2 the pending register, 3 the latch, 4 the priority register (bits 4:0 stored); other addresses read 0. A write takes effect only with all four byte enables set, and writes to address 2 are ignored. After reset the reads are override 0, mask 0x1F, pending 0x12, latch 0, priority 0.
- R2: Mask bits 4:0 always read as 1; a mask write changes only bits 15:5. A disable-interrupts pulse clears bits 15:5.
- R3: A request pulse sets its latch bit one edge later, except request bit 4, which is ignored. Writing the latch clears the bits that are set in the data AND 0xFFEE.
- R4: The current level (curLvl) is the lowest set pending bit other than bits 0 and 4, or 16 (user) when none is set; supervisor is high whenever such a bit is set. The candidate is the lowest set bit of latch AND mask, excluding bit 4. A candidate of level 5 or above is taken only if it is below the current level, or equal to it with self-nesting enabled, and not while pending bit 4 is set above user level. A take sets the pending bit, clears the latch bit and pulses takeStb one edge after the decision. No decision is made in a cycle that carries a register write, return, save, restore or disable pulse.
- R5: Levels 0 and 1 are taken whenever latched, regardless of the current level and of pending bit 4.
- R6: A latched level 2 or 3 that is not below the current level pulses dFault instead of takeStb, and its latch bit is cleared.
- R7: Taking a level of 5 or above also sets pending bit 4.
- R8: saveSel is 0 for level 0, 1 for level 2, 2 for level 3 and 3 otherwise. saveAddr is curPc, except that for level 3 it is nextPc when excCause is below 0x20. For saveSel 3 it is curPc with bit 0 set when the level equals the current level.
- R9: vecReset pulses with a take of level L when override bit L is set and L is 7 or above.
- R10: Return kinds are 0 emulation, 1 NMI, 2 exception and 3 interrupt. Kind 0 is legal only while pending bit 0 is set. Kind 1 is legal only at current level 2, and kind 2 only at current level 3. Kind 3 is legal only when pending bit 0 is clear and the current level is not 2, 3 or user. An illegal return pulses illRet and sets latch bit 3.
- R11: A legal return pulses retStb with retLvl (0, 2, 3, or the current level for kind 3). It clears that pending bit when retLsb is 0, and clears pending bit 4 when the level is 1 or 5 and above.
- R12: A save pulse (retiPush) clears pending bit 4, and a restore pulse (retiPop) sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write |
| regAddr | input | 3 | Register word address |
| regBe | input | 4 | Byte enables; all must be set |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr |
| reqIn | input | 16 | Request pulses, one per level |
| selfNestEn | input | 1 | Allow a level to interrupt itself |
| curPc | input | 32 | Address of the instruction to execute next |
| nextPc | input | 32 | Address following the current instruction |
| excCause | input | 6 | Exception cause code |
| retReq | input | 1 | Return-from-event pulse |
| retKind | input | 2 | Return kind |
| retLsb | input | 1 | Bit 0 of the saved return address |
| cliReq | input | 1 | Disable-interrupts pulse |
| retiPush | input | 1 | Interrupt return register saved to stack |
| retiPop | input | 1 | Interrupt return register restored |
| takeStb | output | 1 | Handler entry strobe |
| takeLvl | output | 4 | Level entered |
| saveSel | output | 2 | Return register to load |
| saveAddr | output | 32 | Value for that register |
| vecReset | output | 1 | Fetch the reset vector instead |
| dFault | output | 1 | Unrecoverable double fault |
| retStb | output | 1 | Legal return strobe |
| retLvl | output | 4 | Level retired |
| illRet | output | 1 | Illegal return strobe |
| supervisor | output | 1 | Core is above user level |
| curLvl | output | 5 | Current level, 16 for user |

## Verification
The bench builds the block with its default widths: a 32-bit data path, 32-bit addresses and a 6-bit cause. These keep all sixteen levels and the full cause range within reach. The bench sweeps every ordered pair of general levels 5 to 15, both with and without self-nesting, as a running level and a new request. It also sweeps all four return kinds against user level and levels 2, 3 and 6, and applies the override at every general level. Expected takes, pending images and saved addresses are computed from level arithmetic in the bench.

// File: rtl/evt_pkg.sv
package evt_pkg;
  localparam int NLVL = 16;
  localparam int LW = $clog2(NLVL);
  typedef logic [LW-1:0] lvl_t;

  localparam lvl_t LV_EMU = 4'd0;
  localparam lvl_t LV_RST = 4'd1;
  localparam lvl_t LV_NMI = 4'd2;
  localparam lvl_t LV_EXC = 4'd3;
  localparam lvl_t LV_GD  = 4'd4;
  localparam lvl_t LV_HWE = 4'd5;
  localparam lvl_t LV_OVR = 4'd7;
  localparam logic [LW:0] USER_LVL = (LW+1)'(NLVL);

  localparam logic [NLVL-1:0] FIXED_MASK = 16'h001F;
  localparam logic [NLVL-1:0] LATCH_CLR_OK = 16'hFFEE;
  localparam logic [NLVL-1:0] PEND_RST = 16'h0012;

  localparam logic [2:0] RG_OVR = 3'd0;
  localparam logic [2:0] RG_MASK = 3'd1;
  localparam logic [2:0] RG_PEND = 3'd2;
  localparam logic [2:0] RG_LATCH = 3'd3;
  localparam logic [2:0] RG_PRIO = 3'd4;

  localparam logic [1:0] RK_EMU = 2'd0;
  localparam logic [1:0] RK_NMI = 2'd1;
  localparam logic [1:0] RK_EXC = 2'd2;
  localparam logic [1:0] RK_INT = 2'd3;

  typedef struct packed {
    logic take;
    logic dfault;
    lvl_t selLvl;
    logic retOk;
    logic retIll;
    lvl_t retLvl;
    logic retClrPend;
    logic retClrGd;
  } ctl_s;
endpackage

// File: rtl/evt_regs.sv
module evt_regs import evt_pkg::*; #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrOk,
  input  logic [2:0]      regAddr,
  input  logic [DW-1:0]   regWdata,
  output logic [DW-1:0]   regRdata,
  input  logic [NLVL-1:0] reqIn,
  input  logic            cliReq,
  input  logic            retiPush,
  input  logic            retiPop,
  input  ctl_s            stb,
  output logic [NLVL-1:0] pendQ,
  output logic [NLVL-1:0] latchQ,
  output logic [NLVL-1:0] maskQ,
  output logic [NLVL-1:0] ovrLvl
);
  localparam int PRW = LW + 1;

  logic [DW-1:0]   ovrQ;
  logic [PRW-1:0]  prioQ;
  logic [NLVL-1:0] latchNext, pendNext, latchSet, latchClr, gdBit, excBit;

  assign gdBit  = NLVL'(1) << LV_GD;
  assign excBit = NLVL'(1) << LV_EXC;
  assign ovrLvl = ovrQ[NLVL-1:0];

  always_comb begin
    latchSet = (reqIn & ~gdBit) | (stb.retIll ? excBit : '0);
    latchClr = '0;
    if (wrOk && regAddr == RG_LATCH) latchClr = regWdata[NLVL-1:0] & LATCH_CLR_OK;
    if (stb.take || stb.dfault) latchClr = latchClr | (NLVL'(1) << stb.selLvl);
    latchNext = (latchQ & ~latchClr) | latchSet;

    pendNext = pendQ;
    if (stb.take) begin
      pendNext[stb.selLvl] = 1'b1;
      if (stb.selLvl >= LV_HWE) pendNext[LV_GD] = 1'b1;
    end
    if (stb.retOk) begin
      if (stb.retClrPend) pendNext[stb.retLvl] = 1'b0;
      if (stb.retClrGd) pendNext[LV_GD] = 1'b0;
    end
    if (retiPush) pendNext[LV_GD] = 1'b0;
    if (retiPop) pendNext[LV_GD] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrQ   <= '0;
      maskQ  <= FIXED_MASK;
      pendQ  <= PEND_RST;
      latchQ <= '0;
      prioQ  <= '0;
    end else begin
      latchQ <= latchNext;
      pendQ  <= pendNext;
      if (wrOk && regAddr == RG_OVR) ovrQ <= regWdata;
      if (wrOk && regAddr == RG_PRIO) prioQ <= regWdata[PRW-1:0];
      if (wrOk && regAddr == RG_MASK) maskQ <= regWdata[NLVL-1:0] | FIXED_MASK;
      else if (cliReq) maskQ <= FIXED_MASK;
    end
  end

  always_comb begin
    case (regAddr)
      RG_OVR:   regRdata = ovrQ;
      RG_MASK:  regRdata = DW'(maskQ);
      RG_PEND:  regRdata = DW'(pendQ);
      RG_LATCH: regRdata = DW'(latchQ);
      RG_PRIO:  regRdata = DW'(prioQ);
      default:  regRdata = '0;
    endcase
  end

  // R2: fixed mask bits stay set through every write and disable
  assert_unmask_R2: assert property (@(posedge clk) disable iff (!rstN)
    maskQ[LV_GD:LV_EMU] == 5'h1F);

  // R12: a lone save pulse leaves the global-disable bit clear
  assert_push_R12: assert property (@(posedge clk) disable iff (!rstN)
    (retiPush && !retiPop) |=> !pendQ[LV_GD]);
endmodule

// File: rtl/evt_ctl.sv
module evt_ctl import evt_pkg::*; #(
  parameter int PCW = 32,
  parameter int CW = 6,
  parameter int XCTH = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NLVL-1:0] pendQ,
  input  logic [NLVL-1:0] latchQ,
  input  logic [NLVL-1:0] maskQ,
  input  logic [NLVL-1:0] ovrLvl,
  input  logic            busy,
  input  logic            selfNestEn,
  input  logic            retReq,
  input  logic [1:0]      retKind,
  input  logic            retLsb,
  input  logic [PCW-1:0]  curPc,
  input  logic [PCW-1:0]  nextPc,
  input  logic [CW-1:0]   excCause,
  output ctl_s            stb,
  output logic [LW:0]     cur,
  output logic            takeStb,
  output lvl_t            takeLvl,
  output logic [1:0]      saveSel,
  output logic [PCW-1:0]  saveAddr,
  output logic            vecReset,
  output logic            dFault,
  output logic            retStb,
  output lvl_t            retLvl,
  output logic            illRet
);
  localparam logic [NLVL-1:0] SKIP_CUR = (NLVL'(1) << LV_EMU) | (NLVL'(1) << LV_GD);

  logic [NLVL-1:0] candVec, curVec;
  lvl_t            cand, rl;
  logic            candOk, doTake, doDf, legal, gdBlock, higher, selfRe;
  logic [1:0]      selN;
  logic [PCW-1:0]  addrN;

  always_comb begin
    candVec = latchQ & maskQ & ~(NLVL'(1) << LV_GD);
    curVec  = pendQ & ~SKIP_CUR;
    candOk = 1'b0;
    cand = '0;
    cur = USER_LVL;
    for (int i = NLVL - 1; i >= 0; i--) begin
      if (candVec[i]) begin
        candOk = 1'b1;
        cand = lvl_t'(i);
      end
      if (curVec[i]) cur = (LW+1)'(i);
    end
    gdBlock = pendQ[LV_GD] && cur != USER_LVL;
    selfRe  = {1'b0, cand} == cur;
    higher  = ({1'b0, cand} < cur) || (selfNestEn && selfRe);

    doTake = 1'b0;
    doDf = 1'b0;
    if (candOk && !busy) begin
      if (cand == LV_EMU || cand == LV_RST) doTake = 1'b1;
      else if (cand == LV_NMI || cand == LV_EXC) begin
        if ({1'b0, cand} < cur) doTake = 1'b1;
        else doDf = 1'b1;
      end else if (!gdBlock && higher) doTake = 1'b1;
    end

    case (retKind)
      RK_EMU: begin rl = LV_EMU; legal = pendQ[LV_EMU]; end
      RK_NMI: begin rl = LV_NMI; legal = cur == {1'b0, LV_NMI}; end
      RK_EXC: begin rl = LV_EXC; legal = cur == {1'b0, LV_EXC}; end
      default: begin
        rl = cur[LW-1:0];
        legal = !pendQ[LV_EMU] && cur != {1'b0, LV_NMI} &&
                cur != {1'b0, LV_EXC} && cur != USER_LVL;
      end
    endcase

    case (cand)
      LV_EMU:  begin selN = RK_EMU; addrN = curPc; end
      LV_NMI:  begin selN = RK_NMI; addrN = curPc; end
      LV_EXC:  begin selN = RK_EXC; addrN = (excCause >= CW'(XCTH)) ? curPc : nextPc; end
      default: begin selN = RK_INT; addrN = curPc | PCW'(selfRe); end
    endcase

    stb.take       = doTake;
    stb.dfault     = doDf;
    stb.selLvl     = cand;
    stb.retOk      = retReq && legal;
    stb.retIll     = retReq && !legal;
    stb.retLvl     = rl;
    stb.retClrPend = !retLsb;
    stb.retClrGd   = rl >= LV_HWE || rl == LV_RST;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      takeStb  <= 1'b0;
      takeLvl  <= '0;
      saveSel  <= '0;
      saveAddr <= '0;
      vecReset <= 1'b0;
      dFault   <= 1'b0;
      retStb   <= 1'b0;
      retLvl   <= '0;
      illRet   <= 1'b0;
    end else begin
      takeStb  <= doTake;
      takeLvl  <= cand;
      saveSel  <= selN;
      saveAddr <= addrN;
      vecReset <= doTake && ovrLvl[cand] && cand >= LV_OVR;
      dFault   <= doDf;
      retStb   <= stb.retOk;
      retLvl   <= rl;
      illRet   <= stb.retIll;
    end
  end

  // R11: entry and return never retire in the same cycle
  assert_excl_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(takeStb && retStb));

  // R6: only NMI or exception levels can double fault
  assert_df_R6: assert property (@(posedge clk) disable iff (!rstN)
    dFault |-> (takeLvl == LV_NMI || takeLvl == LV_EXC));
endmodule

// File: rtl/evt_core.sv
module evt_core import evt_pkg::*; #(
  parameter int DW = 32,
  parameter int PCW = 32,
  parameter int CW = 6,
  parameter int XCTH = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWe,
  input  logic [2:0]      regAddr,
  input  logic [DW/8-1:0] regBe,
  input  logic [DW-1:0]   regWdata,
  output logic [DW-1:0]   regRdata,
  input  logic [NLVL-1:0] reqIn,
  input  logic            selfNestEn,
  input  logic [PCW-1:0]  curPc,
  input  logic [PCW-1:0]  nextPc,
  input  logic [CW-1:0]   excCause,
  input  logic            retReq,
  input  logic [1:0]      retKind,
  input  logic            retLsb,
  input  logic            cliReq,
  input  logic            retiPush,
  input  logic            retiPop,
  output logic            takeStb,
  output logic [LW-1:0]   takeLvl,
  output logic [1:0]      saveSel,
  output logic [PCW-1:0]  saveAddr,
  output logic            vecReset,
  output logic            dFault,
  output logic            retStb,
  output logic [LW-1:0]   retLvl,
  output logic            illRet,
  output logic            supervisor,
  output logic [LW:0]     curLvl
);
  ctl_s            stb;
  logic [NLVL-1:0] pendQ, latchQ, maskQ, ovrLvl;
  logic            wrOk, busy;

  assign wrOk = regWe && (&regBe);
  assign busy = regWe || retReq || retiPush || retiPop || cliReq;
  assign supervisor = curLvl != USER_LVL;

  evt_regs #(.DW(DW)) uRegs (
    .clk(clk), .rstN(rstN), .wrOk(wrOk), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .reqIn(reqIn),
    .cliReq(cliReq), .retiPush(retiPush), .retiPop(retiPop), .stb(stb),
    .pendQ(pendQ), .latchQ(latchQ), .maskQ(maskQ), .ovrLvl(ovrLvl)
  );

  evt_ctl #(.PCW(PCW), .CW(CW), .XCTH(XCTH)) uCtl (
    .clk(clk), .rstN(rstN), .pendQ(pendQ), .latchQ(latchQ), .maskQ(maskQ),
    .ovrLvl(ovrLvl), .busy(busy), .selfNestEn(selfNestEn), .retReq(retReq),
    .retKind(retKind), .retLsb(retLsb), .curPc(curPc), .nextPc(nextPc),
    .excCause(excCause), .stb(stb), .cur(curLvl), .takeStb(takeStb),
    .takeLvl(takeLvl), .saveSel(saveSel), .saveAddr(saveAddr),
    .vecReset(vecReset), .dFault(dFault), .retStb(retStb), .retLvl(retLvl),
    .illRet(illRet)
  );

  // R4: an entered level shows as pending on the strobe cycle
  assert_pendset_R4: assert property (@(posedge clk) disable iff (!rstN)
    takeStb |-> pendQ[takeLvl]);

  // R7: general levels enter with interrupts globally disabled
  assert_gd_R7: assert property (@(posedge clk) disable iff (!rstN)
    (takeStb && takeLvl >= LV_HWE) |-> pendQ[LV_GD]);

  // R9: the reset vector is only substituted for levels 7 and up
  assert_vec_R9: assert property (@(posedge clk) disable iff (!rstN)
    vecReset |-> (takeStb && takeLvl >= LV_OVR));

  // R10: an illegal return leaves an exception request latched
  assert_ill_R10: assert property (@(posedge clk) disable iff (!rstN)
    illRet |-> latchQ[LV_EXC]);
endmodule

// File: tb/sim_evt_core.sv
`timescale 1ns/1ps
module sim_evt_core;
  logic clk = 0, rstN = 0;
  logic regWe = 0;
  logic [2:0] regAddr = 0;
  logic [3:0] regBe = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic [15:0] reqIn = 0;
  logic selfNestEn = 0;
  logic [31:0] curPc = 32'h1000_0040, nextPc = 32'h1000_0044;
  logic [5:0] excCause = 0;
  logic retReq = 0, retLsb = 0, cliReq = 0, retiPush = 0, retiPop = 0;
  logic [1:0] retKind = 0;
  logic takeStb, vecReset, dFault, retStb, illRet, supervisor;
  logic [3:0] takeLvl, retLvl;
  logic [1:0] saveSel;
  logic [31:0] saveAddr;
  logic [4:0] curLvl;
  int nChecks = 0, nErrors = 0;

  evt_core u0 (.*);

  always #10 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input logic [3:0] be);
    regAddr = a; regWdata = d; regBe = be; regWe = 1; tick; regWe = 0; regBe = 0;
  endtask

  task automatic pulseReq(input logic [15:0] v);
    reqIn = v; tick; reqIn = 0; tick;
  endtask

  task automatic doRet(input logic [1:0] k, input logic lsb);
    retKind = k; retLsb = lsb; retReq = 1; tick; retReq = 0; retLsb = 0;
  endtask

  task automatic doReset;
    rstN = 0; tick; tick; rstN = 1; tick;
  endtask

  task automatic toUser;
    doReset; doRet(2'd3, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nErrors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    tick;
    // R1: reset values and map
    doReset;
    rd(3'd0, v); chk("R1 ovr", v, 0);
    rd(3'd1, v); chk("R1 mask", v, 32'h1F);
    rd(3'd2, v); chk("R1 pend", v, 32'h12);
    rd(3'd3, v); chk("R1 latch", v, 0);
    rd(3'd4, v); chk("R1 prio", v, 0);
    rd(3'd5, v); chk("R1 hole", v, 0);
    chk("R4 reset level", {27'd0, curLvl}, 1);
    chk("R4 supervisor", supervisor, 1);
    wr(3'd2, 32'hFFFF, 4'hF); rd(3'd2, v); chk("R1 pend read-only", v, 32'h12);
    wr(3'd4, 32'hFF, 4'hF); rd(3'd4, v); chk("R1 prio", v, 32'h1F);
    wr(3'd0, 32'hFFFF_FFFF, 4'hF); rd(3'd0, v); chk("R1 ovr 32b", v, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0, 4'hF); rd(3'd1, v); chk("R2 fixed mask", v, 32'h1F);

    // R11: leaving reset level clears bit 4 -> user
    toUser;
    rd(3'd2, v); chk("R11 user pend", v, 0);
    chk("R4 user level", {27'd0, curLvl}, 16);
    chk("R4 user mode", supervisor, 0);

    // R3: latch set/clear, request bit 4 ignored
    pulseReq(16'hFFF0);
    chk("R4 masked no take", takeStb, 0);
    rd(3'd3, v); chk("R3 latch", v, 32'hFFE0);
    wr(3'd3, 32'h00F0, 4'hF); rd(3'd3, v); chk("R3 w1c", v, 32'hFF00);
    wr(3'd3, 32'hFF00, 4'h3); rd(3'd3, v); chk("R1 partial ignored", v, 32'hFF00);
    wr(3'd1, 32'hFFFF, 4'hF); rd(3'd1, v); chk("R2 mask write", v, 32'hFFFF);
    tick;
    chk("R4 take after mask", takeStb, 1);
    chk("R4 take level", {28'd0, takeLvl}, 8);
    rd(3'd3, v); chk("R4 latch cleared", v, 32'hFE00);

    // R2: disable interrupts
    toUser;
    wr(3'd1, 32'hFFFF, 4'hF);
    cliReq = 1; tick; cliReq = 0;
    rd(3'd1, v); chk("R2 cli", v, 32'h1F);
    pulseReq(16'h0100);
    chk("R2 cli blocks", takeStb, 0);

    // R4/R7/R8: level pair sweep
    for (int sn = 0; sn < 2; sn++)
      for (int a = 5; a < 16; a++)
        for (int b = 5; b < 16; b++) begin
          logic exp;
          toUser;
          wr(3'd1, 32'hFFFF, 4'hF);
          selfNestEn = sn[0];
          pulseReq(16'(1 << a));
          chk("R4 enter", {31'd0, takeStb}, 1);
          rd(3'd2, v); chk("R7 gd on entry", v, (32'(1) << a) | 32'h10);
          retiPush = 1; tick; retiPush = 0;
          exp = (b < a) || (sn == 1 && b == a);
          pulseReq(16'(1 << b));
          chk("R4 nest decision", {31'd0, takeStb}, {31'd0, exp});
          if (exp) begin
            chk("R4 nest level", {28'd0, takeLvl}, b);
            chk("R8 sel general", {30'd0, saveSel}, 3);
            chk("R8 addr", saveAddr, curPc | 32'(b == a));
            rd(3'd2, v); chk("R7 pend", v, (32'(1) << a) | (32'(1) << b) | 32'h10);
          end else begin
            rd(3'd3, v); chk("R4 stays latched", v, 32'(1) << b);
          end
        end
    selfNestEn = 0;

    // R12: save/restore of interrupt return register
    toUser; wr(3'd1, 32'hFFFF, 4'hF);
    pulseReq(16'h0040);
    retiPush = 1; tick; retiPush = 0;
    rd(3'd2, v); chk("R12 push", v, 32'h40);
    retiPop = 1; tick; retiPop = 0;
    rd(3'd2, v); chk("R12 pop", v, 32'h50);
    pulseReq(16'h0020);
    chk("R4 gd blocks", takeStb, 0);

    // R11: return from general levels, both LSB values
    for (int a = 5; a < 16; a++)
      for (int l = 0; l < 2; l++) begin
        toUser; wr(3'd1, 32'hFFFF, 4'hF);
        pulseReq(16'(1 << a));
        doRet(2'd3, l[0]);
        chk("R11 retStb", retStb, 1);
        chk("R11 retLvl", {28'd0, retLvl}, a);
        rd(3'd2, v); chk("R11 pend after", v, (l == 1) ? (32'(1) << a) : 0);
      end

    // R5: emulation and reset always taken
    toUser; wr(3'd1, 32'hFFFF, 4'hF);
    pulseReq(16'h0200);
    pulseReq(16'h0001);
    chk("R5 emu take", takeStb, 1);
    chk("R5 emu level", {28'd0, takeLvl}, 0);
    chk("R8 emu sel", {30'd0, saveSel}, 0);
    chk("R8 emu addr", saveAddr, curPc);
    rd(3'd2, v); chk("R5 emu pend", v, 32'h211);
    doRet(2'd0, 1'b0);
    chk("R10 rte legal", retStb, 1);
    chk("R11 rte level", {28'd0, retLvl}, 0);
    rd(3'd2, v); chk("R11 rte pend", v, 32'h210);
    pulseReq(16'h0002);
    chk("R5 rst take", takeStb, 1);
    chk("R5 rst level", {28'd0, takeLvl}, 1);
    chk("R8 rst sel", {30'd0, saveSel}, 3);
    rd(3'd2, v); chk("R5 rst pend", v, 32'h212);

    // R6: double fault
    toUser;
    pulseReq(16'h0004);
    chk("R8 nmi sel", {30'd0, saveSel}, 1);
    chk("R8 nmi addr", saveAddr, curPc);
    pulseReq(16'h0008);
    chk("R6 df exc", dFault, 1);
    chk("R6 no take", takeStb, 0);
    rd(3'd3, v); chk("R6 latch cleared", v, 0);
    pulseReq(16'h0004);
    chk("R6 df nmi", dFault, 1);

    // R8: exception save address vs cause
    for (int c = 0; c < 2; c++) begin
      toUser; wr(3'd1, 32'hFFFF, 4'hF);
      pulseReq(16'h0020);
      excCause = (c == 0) ? 6'h1F : 6'h20;
      pulseReq(16'h0008);
      chk("R8 exc take", takeStb, 1);
      chk("R8 exc sel", {30'd0, saveSel}, 2);
      chk("R8 exc addr", saveAddr, (c == 0) ? nextPc : curPc);
    end

    // R9: vector override per level
    for (int a = 5; a < 16; a++) begin
      toUser; wr(3'd1, 32'hFFFF, 4'hF);
      wr(3'd0, 32'hFFFF, 4'hF);
      pulseReq(16'(1 << a));
      chk("R9 override", {31'd0, vecReset}, {31'd0, a >= 7});
    end
    toUser; wr(3'd1, 32'hFFFF, 4'hF);
    pulseReq(16'h0200);
    chk("R9 no override", vecReset, 0);

    // R10: return legality sweep
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++) begin
        logic lg;
        toUser; wr(3'd1, 32'hFFFF, 4'hF);
        if (s == 1) pulseReq(16'h0004);
        if (s == 2) pulseReq(16'h0008);
        if (s == 3) pulseReq(16'h0040);
        lg = (s == 1 && k == 1) || (s == 2 && k == 2) || (s == 3 && k == 3);
        doRet(k[1:0], 1'b0);
        chk("R10 legal", {31'd0, retStb}, {31'd0, lg});
        chk("R10 illegal", {31'd0, illRet}, {31'd0, !lg});
        if (!lg) begin
          rd(3'd3, v); chk("R10 exc latched", v & 32'h8, 32'h8);
        end
      end

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end
endmodule